// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This block watches a 16-bit processor address bus and flags a breakpoint when the address equals a programmed compare value. Software sets the compare value through two byte-wide registers, one for the low half and one for the high half. A control register holds three bits: an arm bit that gates all matching, a mode bit, and a sticky hit flag.

The breakpoint output has two modes. In pulse mode, a match drives the output high for a fixed run of clock cycles, eight by default. In level mode, the output follows the hit flag, so it stays high until software clears the flag. Software clears the flag by writing 1 to its bit.

The register interface is small. A write port takes a select code and a data byte, and the read data is combinational from a separate read select.

Top module: `addr_bkpt_unit`

## Requirements
- R1: A match occurs in a cycle only when `bus_addr` equals {high byte, low byte} on all 16 bits and the arm bit is 1. The hit flag and the output respond at the next rising clock edge.
- R2: While the arm bit (control bit 0) is 0, no address sets the hit flag or raises `bkpt_out`.
- R3: With the mode bit (control bit 1) at 1, a single match holds `bkpt_out` high for exactly PULSE_LEN (8) cycles after the edge that registers it. The output then returns low.
- R4: With the mode bit at 0, `bkpt_out` equals the hit flag. After a match it stays high until the flag is cleared.
- R5: The hit flag is control bit 2. It is set by any match, in either mode, and reads back at bit 2 of the control register.
- R6: A control write with data bit 2 at 1 clears the hit flag. A control write with bit 2 at 0 leaves the flag unchanged. Control writes always load bits 0 and 1 from the data.
- R7: A match while a pulse is running reloads the pulse count to PULSE_LEN.
- R8: When a match and a clearing write fall in the same cycle, the hit flag ends up set.
- R9: After reset, all registers are zero, `bkpt_out` is low and every read returns 0x00.
- R10: The select codes are 0 for the low compare byte, 1 for the high compare byte and 2 for control. Compare bytes read back as written, control reads {5'b0, flag, mode, arm}, and select 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address being watched |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for writes |
| reg_wr_data | input | 8 | Write data |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | 8 | Read data, combinational from reg_rd_sel |
| bkpt_out | output | 1 | Breakpoint output, active high |

## Verification
All state changes land on the rising edge after the stimulus cycle. This includes register writes, the hit flag and the pulse count. `bkpt_out` and `reg_rd_data` are combinational from that state, so each result is valid from that edge until the next one.

The driver applies one cycle of stimulus and pushes the values expected after the following edge into a queue. The monitor pops that entry 5 ns after the same edge and compares it, so every compare sits mid-cycle, one edge behind its stimulus.

A pulse is checked on each of its cycles and on the first low cycle after it. This catches an off-by-one in the pulse length.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned SEL_W  = 2;

    localparam logic [SEL_W-1:0] SEL_CMP_LO = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CMP_HI = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 2'd2;

    localparam int unsigned CTL_ARM  = 0;
    localparam int unsigned CTL_MODE = 1;
    localparam int unsigned CTL_HIT  = 2;

    typedef struct packed {
        logic [REG_W-1:0] cmp_lo;
        logic [REG_W-1:0] cmp_hi;
        logic             arm;
        logic             pmode;
        logic             hit;
    } bkpt_regs_t;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    input  logic               hit_i,
    output logic [2*REG_W-1:0] cmp_addr_o,
    output logic               arm_o,
    output logic               pmode_o,
    output logic               hit_flag_o,
    output logic [REG_W-1:0]   rd_data_o
);
    bkpt_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_CMP_LO: regs_d.cmp_lo = wr_data;
                SEL_CMP_HI: regs_d.cmp_hi = wr_data;
                SEL_CTRL: begin
                    regs_d.arm   = wr_data[CTL_ARM];
                    regs_d.pmode = wr_data[CTL_MODE];
                    if (wr_data[CTL_HIT]) regs_d.hit = 1'b0;
                end
                default: ;
            endcase
        end
        // a match outranks a same-cycle clear
        if (hit_i) regs_d.hit = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_sel)
            SEL_CMP_LO: rd_data_o = regs_q.cmp_lo;
            SEL_CMP_HI: rd_data_o = regs_q.cmp_hi;
            SEL_CTRL: begin
                rd_data_o[CTL_ARM]  = regs_q.arm;
                rd_data_o[CTL_MODE] = regs_q.pmode;
                rd_data_o[CTL_HIT]  = regs_q.hit;
            end
            default: rd_data_o = '0;
        endcase
    end

    assign cmp_addr_o = {regs_q.cmp_hi, regs_q.cmp_lo};
    assign arm_o      = regs_q.arm;
    assign pmode_o    = regs_q.pmode;
    assign hit_flag_o = regs_q.hit;

    assert_hit_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> regs_q.hit);
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && wr_data[CTL_HIT] && !hit_i) |=> !regs_q.hit);
    assert_w0_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.hit && wr_en && wr_sel == SEL_CTRL && !wr_data[CTL_HIT]) |=> regs_q.hit);
    assert_match_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && wr_en && wr_sel == SEL_CTRL && wr_data[CTL_HIT]) |=> regs_q.hit);
endmodule

// File: rtl/bkpt_pulse.sv
module bkpt_pulse #(
    parameter int unsigned PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic active_o
);
    localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hit_i)            cnt_d = LOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active_o = (cnt_q != '0);

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> cnt_q == LOAD);
    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !hit_i) |=> cnt_q == $past(cnt_q) - 1'b1);
    assert_never_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
endmodule

// File: rtl/addr_bkpt_unit.sv
module addr_bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*REG_W-1:0] bus_addr,
    input  logic               reg_wr_en,
    input  logic [SEL_W-1:0]   reg_wr_sel,
    input  logic [REG_W-1:0]   reg_wr_data,
    input  logic [SEL_W-1:0]   reg_rd_sel,
    output logic [REG_W-1:0]   reg_rd_data,
    output logic               bkpt_out
);
    logic [2*REG_W-1:0] cmp_addr;
    logic               arm, pmode, hit_flag, hit, pulse_on;

    assign hit = arm && (bus_addr == cmp_addr);

    bkpt_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_sel     (reg_wr_sel),
        .wr_data    (reg_wr_data),
        .rd_sel     (reg_rd_sel),
        .hit_i      (hit),
        .cmp_addr_o (cmp_addr),
        .arm_o      (arm),
        .pmode_o    (pmode),
        .hit_flag_o (hit_flag),
        .rd_data_o  (reg_rd_data)
    );

    bkpt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .active_o (pulse_on)
    );

    assign bkpt_out = pmode ? pulse_on : hit_flag;

    assert_disarmed_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !$rose(hit_flag));
    assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pmode && hit_flag) |-> bkpt_out);
    assert_match_raises_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> hit_flag);
endmodule

// File: tb/addr_bkpt_unit_tb.sv
module addr_bkpt_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [7:0]  reg_wr_data = '0;
    logic [1:0]  reg_rd_sel = '0;
    logic [7:0]  reg_rd_data;
    logic        bkpt_out;

    always #10 clk = ~clk;

    addr_bkpt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data), .bkpt_out(bkpt_out)
    );

    typedef struct {
        logic       out;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;

    // reference state built from the requirements
    logic [7:0] m_lo = 0, m_hi = 0;
    logic       m_arm = 0, m_mode = 0, m_flag = 0;
    int         m_cnt = 0;

    task automatic step(input logic [15:0] a, input logic we, input logic [1:0] ws,
                        input logic [7:0] wd, input logic [1:0] rs, input string tag);
        logic match;
        exp_t e;
        bus_addr = a; reg_wr_en = we; reg_wr_sel = ws; reg_wr_data = wd; reg_rd_sel = rs;
        match = m_arm && (a == {m_hi, m_lo});
        if (we && ws == 2'd0) m_lo = wd;
        if (we && ws == 2'd1) m_hi = wd;
        if (we && ws == 2'd2) begin
            m_arm = wd[0]; m_mode = wd[1];
            if (wd[2]) m_flag = 1'b0;
        end
        if (match) m_flag = 1'b1;
        if (match) m_cnt = 8;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        e.out = m_mode ? (m_cnt != 0) : m_flag;
        case (rs)
            2'd0: e.rd = m_lo;
            2'd1: e.rd = m_hi;
            2'd2: e.rd = {5'b0, m_flag, m_mode, m_arm};
            default: e.rd = 8'h00;
        endcase
        e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
        #8;
    endtask

    task automatic idle(input int n, input logic [1:0] rs, input string tag);
        for (int i = 0; i < n; i++) step(16'h0000, 1'b0, 2'd0, 8'h00, rs, tag);
    endtask

    // monitor: compare mid-cycle after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (bkpt_out !== e.out || reg_rd_data !== e.rd) begin
                    bad++;
                    $display("FAIL %s: out=%0b rd=%02h expected out=%0b rd=%02h",
                             e.tag, bkpt_out, reg_rd_data, e.out, e.rd);
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: out=%0b rd=%02h expected run to end", bkpt_out, reg_rd_data);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state, sampled while reset is held
        #35;
        for (int s = 0; s < 4; s++) begin
            reg_rd_sel = 2'(s);
            #1;
            total++;
            if (bkpt_out !== 1'b0 || reg_rd_data !== 8'h00) begin
                bad++;
                $display("FAIL R9: out=%0b rd=%02h expected out=0 rd=00", bkpt_out, reg_rd_data);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(1, 2'd2, "R9");

        // R10: compare bytes and select map
        step(16'h0000, 1, 2'd0, 8'h34, 2'd0, "R10");
        step(16'h0000, 1, 2'd1, 8'h12, 2'd1, "R10");
        step(16'h1234, 0, 2'd0, 8'h00, 2'd3, "R10");
        // R2: match address while disarmed
        step(16'h1234, 0, 2'd0, 8'h00, 2'd2, "R2");
        step(16'h1234, 0, 2'd0, 8'h00, 2'd2, "R2");
        // arm, level mode
        step(16'h0000, 1, 2'd2, 8'h01, 2'd2, "R10");
        // R1: near misses in each byte
        step(16'h1235, 0, 2'd0, 8'h00, 2'd2, "R1");
        step(16'h1334, 0, 2'd0, 8'h00, 2'd2, "R1");
        step(16'h9234, 0, 2'd0, 8'h00, 2'd2, "R1");
        step(16'h1234, 0, 2'd0, 8'h00, 2'd2, "R1");
        // R4 / R5: level holds, flag reads back
        idle(5, 2'd2, "R4");
        // R6: write 0 to flag keeps it
        step(16'h0000, 1, 2'd2, 8'h01, 2'd2, "R6");
        idle(2, 2'd2, "R5");
        // R8: clear and match together
        step(16'h1234, 1, 2'd2, 8'h05, 2'd2, "R8");
        idle(2, 2'd2, "R8");
        // R6: clear
        step(16'h0000, 1, 2'd2, 8'h05, 2'd2, "R6");
        idle(2, 2'd2, "R4");
        // R3: pulse mode, clear flag while switching
        step(16'h0000, 1, 2'd2, 8'h07, 2'd2, "R3");
        step(16'h1234, 0, 2'd0, 8'h00, 2'd2, "R3");
        idle(10, 2'd2, "R3");
        // R7: restart during pulse
        step(16'h1234, 0, 2'd0, 8'h00, 2'd0, "R7");
        idle(4, 2'd0, "R7");
        step(16'h1234, 0, 2'd0, 8'h00, 2'd1, "R7");
        idle(10, 2'd1, "R7");
        // R2: disarm in pulse mode, then present match
        step(16'h0000, 1, 2'd2, 8'h06, 2'd2, "R2");
        step(16'h1234, 0, 2'd0, 8'h00, 2'd2, "R2");
        idle(3, 2'd2, "R2");

        #20;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule